// File: doc/BRIEF.md
# Prioritized Abort Status Capture Unit

This block sits beside the memory management logic of a processor core and captures the outcome of a faulting memory access. During one access the surrounding logic may raise several fault requests at once. The request vector has one bit per fault class, and the bit index is the priority, with index 0 the highest. The block keeps the highest-priority request that applies to the access side and turns it into a 5-bit status code. It then updates the instruction-side status register, or the data-side status register together with the two address registers, as the fault class and the side require. It also emits a one-cycle prefetch-abort or data-abort pulse, with a flag telling whether the abort is precise.

All updates happen on the clock edge where `abt_valid` is high. A strobe that carries no fault request that applies leaves every register unchanged and raises no pulse. Software reads the four registers through a select-and-data read port.

Status register layout:
- bits 3:0 hold code[3:0].
- bits 7:4 hold the domain number.
- bit 10 holds code[4].
- bit 11 holds the read/write flag, where 1 means write.
- bit 12 holds the slave/decode-error flag.
- All other bits read as zero.

Top module: `abort_capture`

## Requirements
- R1: `fault_req` bit index is priority, and the lowest set index wins. The order is: 0 alignment, 1 icache maintenance, 2 first-level translation external abort, 3 second-level translation external abort, 4 translation fault on a section, 5 translation fault on a page, 6 access-bit fault on a section, 7 access-bit fault on a page, 8 domain fault on a section, 9 domain fault on a page, 10 permission fault on a section, 11 permission fault on a page, 12 precise external abort, 13 imprecise external abort, 14 debug event.
- R2: The status code for class indices 0 to 14 is, in order: 00001, 00100, 01100, 01110, 00101, 00111, 00011, 00110, 01001, 01011, 01101, 01111, 01000, 10110, 00010. No reserved code is ever written.
- R3: An instruction-side capture (`data_side`=0) has the following effects:
  - It writes only the instruction status register, with the code and the slave/decode-error flag.
  - The domain bits and the read/write bit of that register stay 0.
  - It pulses `pabt_o` with `precise_o`=1.
  - It leaves the data status register and both address registers unchanged.
  - Request bit 1 is ignored on this side.
- R4: A data-side capture writes the data status register and pulses `dabt_o`. It also loads `fault_addr` into the fault address register and `wpt_addr` into the watchpoint address register, except for class 13, which writes the data status register only.
- R5: The data-side domain field is loaded from `dom_in` only for classes 3, 5, 7, 8, 9, 10, 11, 12 and 14. For every other class it keeps its previous value.
- R6: The slave/decode-error bit takes `ext_sd` for classes 2, 3 and 13 and is written 0 otherwise. The read/write bit takes `acc_write` for every class except 1 and 14, and is written 0 for those two.
- R7: On the data side, `icm_op`=1 with a winning class of 4 or 5 reports code 00100 and applies the validity rules of class 1.
- R8: `precise_o` is 0 for a data-side capture of class 13 or class 14, and 1 for every other capture.
- R9: With `abt_valid` low, or with no request that applies to the side, no register changes and no pulse is raised.
- R10: `rd_sel` 0, 1, 2 and 3 return the instruction status, data status, fault address and watchpoint address registers. All four registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| abt_valid | input | 1 | Capture strobe |
| data_side | input | 1 | 1 = data access, 0 = instruction fetch |
| fault_req | input | 15 | Fault requests, bit index = class and priority |
| icm_op | input | 1 | Access is an icache maintenance operation by address |
| dom_in | input | 4 | Domain of the access |
| acc_write | input | 1 | Access was a write |
| ext_sd | input | 1 | External abort slave/decode-error flag |
| fault_addr | input | 32 | Faulting data address |
| wpt_addr | input | 32 | Address recorded for watchpoint reporting |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 32 | Read data |
| pabt_o | output | 1 | Prefetch abort pulse |
| dabt_o | output | 1 | Data abort pulse |
| precise_o | output | 1 | Abort is precise, valid with a pulse |

## Verification
Some properties are checked on every cycle by the assertions:
- the grant vector is at most one-hot;
- the icache maintenance code never reaches the instruction-side register;
- the two abort pulses never coincide, and a pulse never appears without a strobe;
- a status register or an address register does not move without its write enable;
- a data-side write that is not allowed to touch the domain keeps the old domain;
- the instruction-side domain and read/write bits stay zero.

Other behaviour can only be shown by the bench scenarios, which compare every register value read back against an independent model. This covers which class wins among several simultaneous requests, each of the fifteen codes, the per-class validity of the domain, flag and address fields, the maintenance override, and the precise flag.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam int NCLS  = 15;
  localparam int CLS_W = $clog2(NCLS);
  localparam int DOM_W = 4;
  localparam int REG_W = 32;
  localparam int CODE_W = 5;

  localparam logic [CLS_W-1:0] C_ALIGN   = 4'd0;
  localparam logic [CLS_W-1:0] C_ICM     = 4'd1;
  localparam logic [CLS_W-1:0] C_XT_L1   = 4'd2;
  localparam logic [CLS_W-1:0] C_XT_L2   = 4'd3;
  localparam logic [CLS_W-1:0] C_TR_SEC  = 4'd4;
  localparam logic [CLS_W-1:0] C_TR_PG   = 4'd5;
  localparam logic [CLS_W-1:0] C_AB_SEC  = 4'd6;
  localparam logic [CLS_W-1:0] C_AB_PG   = 4'd7;
  localparam logic [CLS_W-1:0] C_DM_SEC  = 4'd8;
  localparam logic [CLS_W-1:0] C_DM_PG   = 4'd9;
  localparam logic [CLS_W-1:0] C_PM_SEC  = 4'd10;
  localparam logic [CLS_W-1:0] C_PM_PG   = 4'd11;
  localparam logic [CLS_W-1:0] C_XA_PREC = 4'd12;
  localparam logic [CLS_W-1:0] C_XA_IMP  = 4'd13;
  localparam logic [CLS_W-1:0] C_DEBUG   = 4'd14;

  // status register field positions
  localparam int F_DOM_LO = 4;
  localparam int F_CODE4  = 10;
  localparam int F_RW     = 11;
  localparam int F_SD     = 12;

  function automatic logic [CODE_W-1:0] class_code(input logic [CLS_W-1:0] c);
    case (c)
      C_ALIGN:   return 5'b00001;
      C_ICM:     return 5'b00100;
      C_XT_L1:   return 5'b01100;
      C_XT_L2:   return 5'b01110;
      C_TR_SEC:  return 5'b00101;
      C_TR_PG:   return 5'b00111;
      C_AB_SEC:  return 5'b00011;
      C_AB_PG:   return 5'b00110;
      C_DM_SEC:  return 5'b01001;
      C_DM_PG:   return 5'b01011;
      C_PM_SEC:  return 5'b01101;
      C_PM_PG:   return 5'b01111;
      C_XA_PREC: return 5'b01000;
      C_XA_IMP:  return 5'b10110;
      default:   return 5'b00010;
    endcase
  endfunction

  function automatic logic dom_valid(input logic [CLS_W-1:0] c);
    return (c == C_XT_L2) || (c == C_TR_PG) || (c == C_AB_PG) ||
           ((c >= C_DM_SEC) && (c <= C_XA_PREC)) || (c == C_DEBUG);
  endfunction

  function automatic logic sd_valid(input logic [CLS_W-1:0] c);
    return (c == C_XT_L1) || (c == C_XT_L2) || (c == C_XA_IMP);
  endfunction

  function automatic logic rw_valid(input logic [CLS_W-1:0] c);
    return (c != C_ICM) && (c != C_DEBUG);
  endfunction

  function automatic logic [REG_W-1:0] pack_fsr(input logic [CODE_W-1:0] code,
                                                input logic [DOM_W-1:0] dom,
                                                input logic rw, input logic sd);
    logic [REG_W-1:0] v;
    v = '0;
    v[3:0] = code[3:0];
    v[F_DOM_LO +: DOM_W] = dom;
    v[F_CODE4] = code[4];
    v[F_RW] = rw;
    v[F_SD] = sd;
    return v;
  endfunction
endpackage

// File: rtl/abort_prio.sv
module abort_prio #(
  parameter int N = abort_pkg::NCLS,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++)
      if (grant[k]) idx = IW'(k);
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R1
  end
endmodule

// File: rtl/abort_encode.sv
module abort_encode
  import abort_pkg::*;
(
  input  logic [CLS_W-1:0]  idx,
  input  logic              any,
  input  logic              data_side,
  input  logic              icm_op,
  output logic [CODE_W-1:0] code,
  output logic              dom_we,
  output logic              sd_ok,
  output logic              rw_ok,
  output logic              ifsr_we,
  output logic              dfsr_we,
  output logic              addr_we,
  output logic              precise
);
  logic             trans_hit;
  logic             icm_override;
  logic [CLS_W-1:0] eff;

  assign trans_hit    = (idx == C_TR_SEC) || (idx == C_TR_PG);
  assign icm_override = any & data_side & icm_op & trans_hit;
  assign eff          = icm_override ? C_ICM : idx;

  assign code    = class_code(eff);
  assign sd_ok   = sd_valid(eff);
  assign rw_ok   = rw_valid(eff);
  assign ifsr_we = any & ~data_side;
  assign dfsr_we = any & data_side;
  assign dom_we  = dfsr_we & dom_valid(eff);
  assign addr_we = dfsr_we & (eff != C_XA_IMP);
  assign precise = ~(data_side & ((eff == C_XA_IMP) || (eff == C_DEBUG)));

  always_comb begin
    if (ifsr_we) AST_NO_ICM_INSTR: assert (code != 5'b00100); // R3
    if (icm_override) AST_OVR_CODE: assert (code == 5'b00100); // R7
  end
endmodule

// File: rtl/abort_regs.sv
module abort_regs
  import abort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifsr_we,
  input  logic              dfsr_we,
  input  logic              addr_we,
  input  logic              dom_we,
  input  logic [CODE_W-1:0] code,
  input  logic [DOM_W-1:0]  dom_in,
  input  logic              rw_bit,
  input  logic              sd_bit,
  input  logic [REG_W-1:0]  fault_addr,
  input  logic [REG_W-1:0]  wpt_addr,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] ifsr_q, dfsr_q, far_q, wfar_q;
  logic [DOM_W-1:0] dom_next;

  assign dom_next = dom_we ? dom_in : dfsr_q[F_DOM_LO +: DOM_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifsr_q <= '0;
      dfsr_q <= '0;
      far_q  <= '0;
      wfar_q <= '0;
    end else begin
      if (ifsr_we) ifsr_q <= pack_fsr(code, '0, 1'b0, sd_bit);
      if (dfsr_we) dfsr_q <= pack_fsr(code, dom_next, rw_bit, sd_bit);
      if (addr_we) begin
        far_q  <= fault_addr;
        wfar_q <= wpt_addr;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = ifsr_q;
      2'd1:    rd_data = dfsr_q;
      2'd2:    rd_data = far_q;
      default: rd_data = wfar_q;
    endcase
  end

  AST_IFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ifsr_we |=> $stable(ifsr_q)); // R3
  AST_IFSR_NODOM: assert property (@(posedge clk) disable iff (!rst_n)
    (ifsr_q[F_DOM_LO +: DOM_W] == '0) && !ifsr_q[F_RW]); // R3
  AST_DFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dfsr_we |=> $stable(dfsr_q)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> ($stable(far_q) && $stable(wfar_q))); // R4
  AST_DOM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dfsr_we && !dom_we) |=> $stable(dfsr_q[F_DOM_LO +: DOM_W])); // R5
endmodule

// File: rtl/abort_capture.sv
module abort_capture
  import abort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abt_valid,
  input  logic              data_side,
  input  logic [NCLS-1:0]   fault_req,
  input  logic              icm_op,
  input  logic [DOM_W-1:0]  dom_in,
  input  logic              acc_write,
  input  logic              ext_sd,
  input  logic [REG_W-1:0]  fault_addr,
  input  logic [REG_W-1:0]  wpt_addr,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              pabt_o,
  output logic              dabt_o,
  output logic              precise_o
);
  logic [NCLS-1:0]   side_mask, req_eff, grant;
  logic [CLS_W-1:0]  win_idx;
  logic              win_any;
  logic [CODE_W-1:0] code;
  logic              dom_we, sd_ok, rw_ok, ifsr_we, dfsr_we, addr_we, precise;

  // icache maintenance request never applies to instruction fetches
  always_comb begin
    side_mask = '1;
    if (!data_side) side_mask[C_ICM] = 1'b0;
  end
  assign req_eff = abt_valid ? (fault_req & side_mask) : '0;

  abort_prio #(.N(NCLS)) u_prio (
    .req(req_eff), .grant(grant), .idx(win_idx), .any(win_any)
  );

  abort_encode u_enc (
    .idx(win_idx), .any(win_any), .data_side(data_side), .icm_op(icm_op),
    .code(code), .dom_we(dom_we), .sd_ok(sd_ok), .rw_ok(rw_ok),
    .ifsr_we(ifsr_we), .dfsr_we(dfsr_we), .addr_we(addr_we), .precise(precise)
  );

  abort_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ifsr_we(ifsr_we), .dfsr_we(dfsr_we),
    .addr_we(addr_we), .dom_we(dom_we), .code(code), .dom_in(dom_in),
    .rw_bit(acc_write & rw_ok), .sd_bit(ext_sd & sd_ok),
    .fault_addr(fault_addr), .wpt_addr(wpt_addr),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pabt_o    <= 1'b0;
      dabt_o    <= 1'b0;
      precise_o <= 1'b0;
    end else begin
      pabt_o    <= ifsr_we;
      dabt_o    <= dfsr_we;
      precise_o <= (ifsr_we | dfsr_we) & precise;
    end
  end

  AST_ABT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pabt_o && dabt_o)); // R3
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (pabt_o || dabt_o) |-> $past(abt_valid)); // R9
  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~fault_req) == '0)); // R1
  AST_PABT_PRECISE: assert property (@(posedge clk) disable iff (!rst_n)
    pabt_o |-> precise_o); // R8
endmodule

// File: tb/abort_capture_test.sv
`timescale 1ns/100ps
module abort_capture_test;
  typedef struct {
    string       tag;
    logic [31:0] ifsr, dfsr, far, wfar;
    logic        pabt, dabt, prec;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        abt_valid = 0, data_side = 0, icm_op = 0, acc_write = 0, ext_sd = 0;
  logic [14:0] fault_req = '0;
  logic [3:0]  dom_in = '0;
  logic [31:0] fault_addr = '0, wpt_addr = '0, rd_data;
  logic [1:0]  rd_sel = '0;
  logic        pabt_o, dabt_o, precise_o;

  int n_run = 0, n_fail = 0;
  item_t sb_q[$];
  event go;
  logic [31:0] m_ifsr = 0, m_dfsr = 0, m_far = 0, m_wfar = 0;

  localparam logic [14:0] DOM_M = 15'b101111110101000;
  localparam logic [14:0] SD_M  = 15'b010000000001100;
  localparam logic [14:0] RW_M  = 15'b011111111111101;

  always #2.5 clk = ~clk;

  abort_capture uut (
    .clk(clk), .rst_n(rst_n), .abt_valid(abt_valid), .data_side(data_side),
    .fault_req(fault_req), .icm_op(icm_op), .dom_in(dom_in), .acc_write(acc_write),
    .ext_sd(ext_sd), .fault_addr(fault_addr), .wpt_addr(wpt_addr),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .pabt_o(pabt_o), .dabt_o(dabt_o), .precise_o(precise_o)
  );

  function automatic logic [4:0] tcode(input int c);
    logic [4:0] t [15] = '{5'h01, 5'h04, 5'h0C, 5'h0E, 5'h05, 5'h07, 5'h03, 5'h06,
                           5'h09, 5'h0B, 5'h0D, 5'h0F, 5'h08, 5'h16, 5'h02};
    return t[c];
  endfunction

  function automatic logic [31:0] fsr(input logic [4:0] c, input logic [3:0] d,
                                      input logic rw, input logic sd);
    return {19'd0, sd, rw, c[4], 2'b00, d, c[3:0]};
  endfunction

  task automatic drive(input string tag, input logic v, input logic side,
                       input logic [14:0] req, input logic icm, input logic [3:0] d,
                       input logic rw, input logic sd, input logic [31:0] fa,
                       input logic [31:0] wa);
    item_t it;
    logic [14:0] m;
    int k, e;
    m = v ? req : '0;
    if (!side) m[1] = 1'b0;
    k = -1;
    for (int i = 14; i >= 0; i--) if (m[i]) k = i;
    it.pabt = 0; it.dabt = 0; it.prec = 0;
    if (k >= 0) begin
      e = (side && icm && (k == 4 || k == 5)) ? 1 : k;
      if (!side) begin
        m_ifsr = fsr(tcode(e), 4'd0, 1'b0, sd & SD_M[e]);
        it.pabt = 1; it.prec = 1;
      end else begin
        m_dfsr = fsr(tcode(e), DOM_M[e] ? d : m_dfsr[7:4], rw & RW_M[e], sd & SD_M[e]);
        if (e != 13) begin m_far = fa; m_wfar = wa; end
        it.dabt = 1; it.prec = !(e == 13 || e == 14);
      end
    end
    it.tag = tag; it.ifsr = m_ifsr; it.dfsr = m_dfsr; it.far = m_far; it.wfar = m_wfar;
    @(negedge clk);
    abt_valid = v; data_side = side; fault_req = req; icm_op = icm; dom_in = d;
    acc_write = rw; ext_sd = sd; fault_addr = fa; wpt_addr = wa;
    @(posedge clk);
    @(negedge clk);
    abt_valid = 0; fault_req = '0; icm_op = 0;
    sb_q.push_back(it);
    -> go;
    wait (sb_q.size() == 0);
  endtask

  task automatic read_all(output logic [31:0] r[4]);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.2;
      r[s] = rd_data;
    end
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] r[4];
    forever begin
      @(go);
      it = sb_q[0];
      read_all(r);
      n_run++;
      if (r[0] !== it.ifsr || r[1] !== it.dfsr || r[2] !== it.far || r[3] !== it.wfar ||
          pabt_o !== it.pabt || dabt_o !== it.dabt ||
          ((it.pabt || it.dabt) && precise_o !== it.prec)) begin
        n_fail++;
        $display("FAIL %s: got ifsr=%h dfsr=%h far=%h wfar=%h pabt=%b dabt=%b prec=%b exp ifsr=%h dfsr=%h far=%h wfar=%h pabt=%b dabt=%b prec=%b",
                 it.tag, r[0], r[1], r[2], r[3], pabt_o, dabt_o, precise_o,
                 it.ifsr, it.dfsr, it.far, it.wfar, it.pabt, it.dabt, it.prec);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] r[4];
    repeat (3) @(negedge clk);
    read_all(r);
    n_run++;
    if ((r[0] | r[1] | r[2] | r[3]) !== 0 || pabt_o !== 0 || dabt_o !== 0) begin
      n_fail++;
      $display("FAIL R10 reset: got %h %h %h %h exp zero", r[0], r[1], r[2], r[3]);
    end
    rst_n = 1;
    // R2 R4 R5 R6 every class alone on the data side
    for (int c = 0; c < 15; c++)
      drive($sformatf("R2 R4 R5 R6 data class %0d", c), 1, 1, 15'(1) << c, 0,
            4'(c + 1), 1, 1, 32'h1000 + c, 32'h2000 + c);
    drive("R1 priority align over all", 1, 1, 15'h7FFF, 0, 4'hA, 1, 1, 32'hA0, 32'hB0);
    drive("R1 second-level over page perm", 1, 1, 15'b000100000001000, 0, 4'h3, 0, 1, 32'hA1, 32'hB1);
    drive("R1 R5 domain page over precise ext", 1, 1, 15'b001001000000000, 0, 4'h6, 1, 0, 32'hA2, 32'hB2);
    drive("R3 instr permission page", 1, 0, 15'b000100000000000, 0, 4'h7, 1, 1, 32'hC0, 32'hC1);
    drive("R3 R6 instr ext translation", 1, 0, 15'b000000000000100, 0, 4'h7, 1, 1, 32'hC2, 32'hC3);
    drive("R3 instr icm request ignored", 1, 0, 15'b000000000000010, 0, 4'h7, 1, 1, 32'hC4, 32'hC5);
    drive("R3 R1 instr icm masked, translation wins", 1, 0, 15'b000000000110010, 0, 4'h1, 1, 0, 32'hC6, 32'hC7);
    drive("R4 R8 data imprecise ext only DFSR", 1, 1, 15'b010000000000000, 0, 4'h9, 1, 1, 32'hD0, 32'hD1);
    drive("R8 data debug", 1, 1, 15'b100000000000000, 0, 4'h5, 1, 1, 32'hD2, 32'hD3);
    drive("R8 instr debug precise", 1, 0, 15'b100000000000000, 0, 4'h5, 1, 1, 32'hD4, 32'hD5);
    drive("R7 icm override section", 1, 1, 15'b000000000010000, 1, 4'hE, 1, 0, 32'hE0, 32'hE1);
    drive("R7 icm override page", 1, 1, 15'b000000000100000, 1, 4'hE, 1, 0, 32'hE2, 32'hE3);
    drive("R7 icm flag no effect on perm", 1, 1, 15'b000100000000000, 1, 4'h2, 1, 0, 32'hE4, 32'hE5);
    drive("R9 strobe low", 0, 1, 15'h7FFF, 0, 4'hF, 1, 1, 32'hF0, 32'hF1);
    drive("R9 strobe with no request", 1, 1, 15'h0000, 0, 4'hF, 1, 1, 32'hF2, 32'hF3);
    drive("R5 R10 domain retained on align", 1, 1, 15'b000000000000001, 0, 4'hC, 0, 0, 32'hF4, 32'hF5);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule